// File: doc/BRIEF.md
# Device Select Strobe Decoder

This block sits between a small sequencing processor and the peripherals on its shared 8-bit data bus. Each bus cycle, the processor presents a 4-bit select code, a read/write qualifier and a strobe-enable timing pulse. The block turns these into one of two strobe banks. A read strobe tells the addressed register or memory to put its data on the bus. A write strobe tells the addressed device to latch the bus data.

The same decode sets the direction of the bus transceiver. The transceiver drives toward the processor only while a read strobe is active. At all other times it stays in receive mode, so two drivers never meet on the bus.

All outputs are registered. A request sampled at one rising edge shows on the strobes just after that edge and lasts one cycle. There is no data stream through the block, so every pin is a plain control pin with no valid/ready handshake and no back-pressure.

Top module: `dsd_strobe_decoder`

## Requirements
- R1: While `rst_n` is low, every read strobe and every write strobe is 0 and `bus_drive_to_cpu` is 0 (receive mode), whatever the other inputs are.
- R2: If a rising edge samples `sel_strobe`=1, `sel_is_read`=1 and `sel_code`=k with k in 1..15, then after that edge `rd_strobe` bit k-1 is 1 and every other read and write strobe bit is 0.
- R3: If a rising edge samples `sel_strobe`=1, `sel_is_read`=0 and `sel_code`=k with k in 1..15, then after that edge `wr_strobe` bit k-1 is 1 and every other write and read strobe bit is 0.
- R4: Code value 0 addresses no device. If a rising edge samples `sel_code`=0, all strobes are 0 and `bus_drive_to_cpu` is 0 after that edge, whatever `sel_strobe` and `sel_is_read` are.
- R5: If a rising edge samples `sel_strobe`=0, all strobes are 0 and `bus_drive_to_cpu` is 0 after that edge, whatever the code and qualifier are.
- R6: In every cycle, at most one strobe across both banks together (30 bits) is 1.
- R7: `bus_drive_to_cpu` is 1 (drive toward the processor) exactly in the cycles where a read strobe is active. It is 0 (receive) in every other cycle, including write cycles.
- R8: Outputs have a latency of one clock. A strobe lasts one cycle for each sampled enable cycle, and all strobes drop in the cycle after the enable is sampled low. Back-to-back requests with different codes or directions are each decoded in their own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_code | input | 4 | Device select code; 0 addresses no device |
| sel_is_read | input | 1 | 1 = read access, 0 = write access |
| sel_strobe | input | 1 | Strobe-enable timing pulse |
| rd_strobe | output | 15 | Read strobes; bit k-1 serves code k |
| wr_strobe | output | 15 | Write strobes; bit k-1 serves code k |
| bus_drive_to_cpu | output | 1 | Transceiver direction: 1 drives toward the processor, 0 receives |

## Verification
The assertions check the structural invariants on every cycle:
- no more than one strobe is active across both banks;
- the transceiver direction follows the read bank;
- a sampled enable of the matching kind yields exactly one bit in that bank;
- a sampled low enable or code 0 yields silence.

Only the bench scenarios can show that the correct bit position is chosen for each of the 15 codes in each bank. They also show that reset overrides an active request, and that alternating read and write cycles decode in their own cycles with no smearing.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } dsd_access_e;

endpackage

// File: rtl/dsd_req_classify.sv
module dsd_req_classify
  import dsd_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code,
  input  logic              is_read,
  input  logic              enable,
  output dsd_access_e       kind
);

  logic addressed;

  // Code 0 is the idle code; it never reaches a device.
  assign addressed = (code != '0);

  always_comb begin
    if (!enable || !addressed) begin
      kind = ACC_NONE;
    end else if (is_read) begin
      kind = ACC_READ;
    end else begin
      kind = ACC_WRITE;
    end
  end

endmodule

// File: rtl/dsd_strobe_bank.sv
module dsd_strobe_bank
  import dsd_pkg::*;
#(
  parameter int          CODE_W  = 4,
  parameter int          PORTS   = (1 << CODE_W) - 1,
  parameter dsd_access_e SERVES  = ACC_READ
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dsd_access_e       kind,
  input  logic [CODE_W-1:0] code,
  output logic [PORTS-1:0]  strobe
);

  logic [PORTS-1:0] hit;
  logic             mine;
  logic             past_ok;

  assign mine = (kind == SERVES);

  // One comparator per port; port p answers to code p+1.
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign hit[p] = mine && (code == CODE_W'(p + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe <= '0;
    end else begin
      strobe <= hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
    end
  end

  AST_BANK_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(kind == SERVES)) |-> ($countones(strobe) == 1)) else $error("bank hit count"); // R2, R3
  AST_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(kind != SERVES)) |-> (strobe == '0)) else $error("bank not quiet"); // R5

endmodule

// File: rtl/dsd_xcvr_dir.sv
module dsd_xcvr_dir
  import dsd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  dsd_access_e kind,
  output logic        drive_to_cpu
);

  // Receive is the resting state; only a decoded read turns it around.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_to_cpu <= 1'b0;
    end else begin
      drive_to_cpu <= (kind == ACC_READ);
    end
  end

endmodule

// File: rtl/dsd_strobe_decoder.sv
module dsd_strobe_decoder
  import dsd_pkg::*;
#(
  parameter int CODE_W = 4,
  localparam int PORTS = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] sel_code,
  input  logic              sel_is_read,
  input  logic              sel_strobe,
  output logic [PORTS-1:0]  rd_strobe,
  output logic [PORTS-1:0]  wr_strobe,
  output logic              bus_drive_to_cpu
);

  dsd_access_e kind;
  logic        past_ok;

  dsd_req_classify #(.CODE_W(CODE_W)) u_classify (
    .code    (sel_code),
    .is_read (sel_is_read),
    .enable  (sel_strobe),
    .kind    (kind)
  );

  dsd_strobe_bank #(.CODE_W(CODE_W), .PORTS(PORTS), .SERVES(ACC_READ)) u_rd_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .kind   (kind),
    .code   (sel_code),
    .strobe (rd_strobe)
  );

  dsd_strobe_bank #(.CODE_W(CODE_W), .PORTS(PORTS), .SERVES(ACC_WRITE)) u_wr_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .kind   (kind),
    .code   (sel_code),
    .strobe (wr_strobe)
  );

  dsd_xcvr_dir u_xcvr (
    .clk          (clk),
    .rst_n        (rst_n),
    .kind         (kind),
    .drive_to_cpu (bus_drive_to_cpu)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_strobe, wr_strobe})) else $error("more than one strobe"); // R6
  AST_DIR_TRACKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_to_cpu == (rd_strobe != '0)) else $error("direction mismatch"); // R7
  AST_CODE0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(sel_code == '0)) |-> ({rd_strobe, wr_strobe, bus_drive_to_cpu} == '0)) else $error("code 0 strobed"); // R4
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(sel_strobe)) |-> ({rd_strobe, wr_strobe, bus_drive_to_cpu} == '0)) else $error("strobe without enable"); // R5

endmodule

// File: tb/dsd_strobe_decoder_tb.sv
module dsd_strobe_decoder_tb;

  localparam int CODE_W = 4;
  localparam int PORTS  = (1 << CODE_W) - 1;

  typedef struct {
    logic [PORTS-1:0] rd;
    logic [PORTS-1:0] wr;
    logic             dir;
    string            tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CODE_W-1:0] sel_code = '0;
  logic              sel_is_read = 1'b0;
  logic              sel_strobe = 1'b0;
  logic [PORTS-1:0]  rd_strobe;
  logic [PORTS-1:0]  wr_strobe;
  logic              bus_drive_to_cpu;

  int   checks = 0;
  int   errors = 0;
  bit   stim_done = 1'b0;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  dsd_strobe_decoder #(.CODE_W(CODE_W)) u_dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .sel_code         (sel_code),
    .sel_is_read      (sel_is_read),
    .sel_strobe       (sel_strobe),
    .rd_strobe        (rd_strobe),
    .wr_strobe        (wr_strobe),
    .bus_drive_to_cpu (bus_drive_to_cpu)
  );

  // Driver: applies one request per cycle and queues the result the requirements predict.
  task automatic drive(input logic [CODE_W-1:0] code, input logic rd, input logic en, input string tag);
    exp_t e;
    @(negedge clk);
    sel_code    = code;
    sel_is_read = rd;
    sel_strobe  = en;
    e.rd  = '0;
    e.wr  = '0;
    e.dir = 1'b0;
    e.tag = tag;
    if (en && code != '0) begin
      if (rd) begin
        e.rd[code-1] = 1'b1;
        e.dir = 1'b1;
      end else begin
        e.wr[code-1] = 1'b1;
      end
    end
    sb_q.push_back(e);
  endtask

  // Monitor: compares two time units after each edge, well clear of it.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (rd_strobe !== e.rd || wr_strobe !== e.wr || bus_drive_to_cpu !== e.dir) begin
          errors++;
          $display("FAIL %s: rd=%h wr=%h dir=%b expected rd=%h wr=%h dir=%b",
                   e.tag, rd_strobe, wr_strobe, bus_drive_to_cpu, e.rd, e.wr, e.dir);
        end
        checks++;
        if ($countones({rd_strobe, wr_strobe}) > 1) begin
          errors++;
          $display("FAIL R6: %0d strobes active, expected at most 1",
                   $countones({rd_strobe, wr_strobe}));
        end
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset dominates an active read request.
    sel_code = 4'd3;
    sel_is_read = 1'b1;
    sel_strobe = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (rd_strobe !== '0 || wr_strobe !== '0 || bus_drive_to_cpu !== 1'b0) begin
      errors++;
      $display("FAIL R1: rd=%h wr=%h dir=%b expected all 0", rd_strobe, wr_strobe, bus_drive_to_cpu);
    end
    @(negedge clk);
    sel_strobe = 1'b0;
    rst_n = 1'b1;

    for (int k = 1; k <= PORTS; k++) drive(CODE_W'(k), 1'b1, 1'b1, "R2");
    for (int k = 1; k <= PORTS; k++) drive(CODE_W'(k), 1'b0, 1'b1, "R3");
    drive(4'd0, 1'b1, 1'b1, "R4");
    drive(4'd0, 1'b0, 1'b1, "R4");
    drive(4'd7, 1'b1, 1'b0, "R5");
    drive(4'd15, 1'b0, 1'b0, "R5");
    drive(4'd9, 1'b0, 1'b1, "R7");
    drive(4'd9, 1'b1, 1'b1, "R7");
    drive(4'd9, 1'b1, 1'b0, "R8");
    for (int k = 1; k <= 6; k++) drive(CODE_W'(16 - k), k[0], 1'b1, "R8");
    drive(4'd1, 1'b1, 1'b0, "R8");
    drive(4'd0, 1'b0, 1'b0, "R5");
    @(posedge clk);
    #3;
    stim_done = 1'b1;
  end

  initial begin
    wait (stim_done);
    if (sb_q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL R8: %0d results never observed, expected 0", sb_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule